// File: doc/BRIEF.md
# Interrupt acceptance and vectoring unit

This unit sits beside the instruction sequencer of a small 8-bit processor core and decides, at each instruction boundary, whether a pending interrupt is taken. It owns the two interrupt-enable flags (the live flag `iff1` and the saved copy `iff2`), the vector page register, the refresh counter, the three-way maskable mode and the stack pointer used for the return-address push. The accumulator/flag word sits here as well, so that a single reset sets both 16-bit registers to all ones. When an interrupt is taken, the unit pushes the return PC through a word-write port. In the vectored mode it also reads the new PC through a word-read port. It then reports the new PC and a cycle count to the core.

The core presents an instruction boundary together with the current PC. On the same cycle it can present a control code for enable, disable, mode select, return-from-interrupt and return-from-NMI. Any cycle that is not busy may also carry a write to the vector page, refresh, stack or flag-word registers. The sequencer runs through the states `ST_IDLE`, `ST_PUSH`, `ST_VEC` and `ST_REPORT`:
- IDLE→PUSH when a grant needs a push.
- IDLE→REPORT when the mode-0 byte is not a restart.
- PUSH→VEC in the vectored mode.
- PUSH→REPORT otherwise.
- VEC→REPORT on `rd_ack`.
- REPORT→IDLE always.

Top module: `irq_accept_unit`

## Requirements
- R1: Reset clears the vector page, the refresh counter, `iff1` and `iff2`, selects mode 0, sets `sp` and `af` to 0xFFFF and leaves `busy` low.
- R2: A maskable request at a boundary while `iff1` is 0 is ignored. There is no push, no report, `busy` stays low and no register changes.
- R3: Accepting a maskable request clears both `iff1` and `iff2`.
- R4: Every accepted interrupt, maskable or NMI, adds one to bits 6:0 of the refresh counter with wrap. Bit 7 is kept.
- R5: In mode 1 the unit writes the boundary PC as a word at `sp`-2, lowers `sp` by 2, and reports new PC 0x0038 with 13 cycles.
- R6: In mode 2 the unit pushes the PC like R5. It then reads a word at the pointer {vector page, data bus byte} and reports that word as the new PC with 19 cycles. When `MASK_VEC_LSB` is 1, pointer bit 0 is forced to 0 (the default is 0).
- R7: In mode 0 a restart byte of the form 11yyy111 is pushed like R5 and reports target 8×yyy with 13 cycles. Any other byte causes no push and reports `resp_m0_exec`=1, the boundary PC unchanged and 2 cycles.
- R8: An NMI is taken whatever `iff1` holds. It copies `iff1` into `iff2`, clears `iff1`, pushes like R5, and reports 0x0066 with 11 cycles and `resp_nmi`=1.
- R9: Control code 3 selects the mode from the 3-bit field y. y[1:0] of 0 or 1 gives mode 0. Otherwise y[0]=0 gives mode 1 and y[0]=1 gives mode 2.
- R10: Control codes 4 and 5 copy `iff2` into `iff1`. Code 1 sets both flags, code 2 clears both, and codes 6 and 7 change nothing.
- R11: A boundary that carries any nonzero control code accepts nothing. Its requests wait for the next boundary, so no interrupt follows an enable or disable until one more instruction has ended.
- R12: A rising edge on `nmi_in` is latched until serviced. When an NMI and a maskable request are both pending at a boundary, the NMI is taken.
- R13: Timing after the accepting edge: `wr_req` is high in the first cycle. For a mode-2 interrupt, `rd_req` is high from the second cycle until `rd_ack`. `done` pulses for one cycle after the push, or after the read when there is one. `busy` falls in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_boundary | input | 1 | Instruction boundary strobe |
| pc_in | input | 16 | PC to return to at this boundary |
| int_req | input | 1 | Maskable request level |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| data_bus | input | 8 | Byte supplied by the interrupting device |
| ctl_op | input | 3 | Control code: 0 none, 1 enable, 2 disable, 3 mode select, 4 return-int, 5 return-NMI |
| ctl_im_field | input | 3 | Mode-select field y |
| i_we | input | 1 | Vector page write |
| i_wdata | input | 8 | Vector page write data |
| r_we | input | 1 | Refresh counter write |
| r_wdata | input | 8 | Refresh counter write data |
| sp_we | input | 1 | Stack pointer write |
| sp_wdata | input | 16 | Stack pointer write data |
| af_we | input | 1 | Flag-word write |
| af_wdata | input | 16 | Flag-word write data |
| wr_req | output | 1 | Word write strobe (return-PC push) |
| wr_addr | output | 16 | Word write address |
| wr_data | output | 16 | Word write data |
| rd_req | output | 1 | Word read request (vector fetch) |
| rd_addr | output | 16 | Word read address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 16 | Read data |
| busy | output | 1 | Response in progress |
| done | output | 1 | Response report strobe |
| resp_pc | output | 16 | New PC |
| resp_cycles | output | 5 | Cycle cost of the response |
| resp_nmi | output | 1 | Response was an NMI |
| resp_m0_exec | output | 1 | Core must execute the mode-0 byte itself |
| iff1 | output | 1 | Live enable flag |
| iff2 | output | 1 | Saved enable flag |
| i_reg | output | 8 | Vector page register |
| r_reg | output | 8 | Refresh counter |
| im_mode | output | 2 | Maskable mode 0, 1 or 2 |
| sp | output | 16 | Stack pointer |
| af | output | 16 | Flag word |

## Verification
Directed patterns take each mode in turn. They separate the fixed jump of mode 1, the pointer read of mode 2, and the two mode-0 cases (restart byte and plain byte), which differ in both push and cycle count. The refresh values 0x7F and 0xFF show whether bit 7 is kept across the wrap. An NMI taken with the enable flag both clear and set shows whether `iff2` receives a copy or just a clear. Boundaries that carry controls, an NMI edge and a held maskable request show the deferral and the priority order. Seeded random sequences then mix all of these with register writes against a bench model.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;
    localparam int CYC_W  = 5;

    localparam logic [2:0] OP_NONE = 3'd0;
    localparam logic [2:0] OP_EI   = 3'd1;
    localparam logic [2:0] OP_DI   = 3'd2;
    localparam logic [2:0] OP_IM   = 3'd3;
    localparam logic [2:0] OP_RETI = 3'd4;
    localparam logic [2:0] OP_RETN = 3'd5;

    typedef enum logic [1:0] {IM0 = 2'd0, IM1 = 2'd1, IM2 = 2'd2} im_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PUSH   = 2'd1,
        ST_VEC    = 2'd2,
        ST_REPORT = 2'd3
    } st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [CYC_W-1:0]  cyc;
        logic              push;
        logic              vec_rd;
        logic              m0_exec;
    } plan_t;
endpackage

// File: rtl/irq_ctl_decode.sv
module irq_ctl_decode
    import irq_pkg::*;
(
    input  logic       en,
    input  logic [2:0] op,
    input  logic [2:0] y,
    output logic       set_en,
    output logic       clr_en,
    output logic       restore,
    output logic       im_we,
    output im_e        im_new
);
    always_comb begin
        set_en  = 1'b0;
        clr_en  = 1'b0;
        restore = 1'b0;
        im_we   = 1'b0;
        if (y[1:0] <= 2'd1)
            im_new = IM0;
        else if (!y[0])
            im_new = IM1;
        else
            im_new = IM2;
        if (en) begin
            unique case (op)
                OP_EI:           set_en  = 1'b1;
                OP_DI:           clr_en  = 1'b1;
                OP_IM:           im_we   = 1'b1;
                OP_RETI, OP_RETN: restore = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
    input  logic boundary,
    input  logic busy,
    input  logic ctl_present,
    input  logic nmi_now,
    input  logic int_req,
    input  logic iff1,
    output logic grant_nmi,
    output logic grant_int
);
    logic window;
    always_comb begin
        window    = boundary && !busy && !ctl_present;
        grant_nmi = window && nmi_now;
        grant_int = window && !nmi_now && int_req && iff1;
    end
endmodule

// File: rtl/irq_vector_calc.sv
module irq_vector_calc
    import irq_pkg::*;
#(
    parameter logic              MASK_VEC_LSB = 1'b0,
    parameter logic [ADDR_W-1:0] NMI_TARGET   = 16'h0066,
    parameter logic [ADDR_W-1:0] M1_TARGET    = 16'h0038,
    parameter int                CYC_NMI      = 11,
    parameter int                CYC_IM1      = 13,
    parameter int                CYC_IM2      = 19,
    parameter int                CYC_RST      = 13,
    parameter int                CYC_M0_BASE  = 2
) (
    input  logic              is_nmi,
    input  im_e               mode,
    input  logic [BYTE_W-1:0] data,
    input  logic [BYTE_W-1:0] page,
    input  logic [ADDR_W-1:0] pc_in,
    output plan_t             plan
);
    logic [ADDR_W-1:0] ptr;
    logic              is_rst;

    always_comb begin
        ptr    = {page, data[BYTE_W-1:1], data[0] & ~MASK_VEC_LSB};
        is_rst = (data[7:6] == 2'b11) && (data[2:0] == 3'b111);
        plan   = '0;
        if (is_nmi) begin
            plan.pc   = NMI_TARGET;
            plan.cyc  = CYC_W'(CYC_NMI);
            plan.push = 1'b1;
        end else begin
            unique case (mode)
                IM1: begin
                    plan.pc   = M1_TARGET;
                    plan.cyc  = CYC_W'(CYC_IM1);
                    plan.push = 1'b1;
                end
                IM2: begin
                    plan.pc     = ptr;
                    plan.cyc    = CYC_W'(CYC_IM2);
                    plan.push   = 1'b1;
                    plan.vec_rd = 1'b1;
                end
                default: begin
                    if (is_rst) begin
                        plan.pc   = ADDR_W'({data[5:3], 3'b000});
                        plan.cyc  = CYC_W'(CYC_RST);
                        plan.push = 1'b1;
                    end else begin
                        plan.pc      = pc_in;
                        plan.cyc     = CYC_W'(CYC_M0_BASE);
                        plan.m0_exec = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_pkg::*;
#(
    parameter logic MASK_VEC_LSB = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_boundary,
    input  logic [15:0] pc_in,
    input  logic        int_req,
    input  logic        nmi_in,
    input  logic [7:0]  data_bus,
    input  logic [2:0]  ctl_op,
    input  logic [2:0]  ctl_im_field,
    input  logic        i_we,
    input  logic [7:0]  i_wdata,
    input  logic        r_we,
    input  logic [7:0]  r_wdata,
    input  logic        sp_we,
    input  logic [15:0] sp_wdata,
    input  logic        af_we,
    input  logic [15:0] af_wdata,
    output logic        wr_req,
    output logic [15:0] wr_addr,
    output logic [15:0] wr_data,
    output logic        rd_req,
    output logic [15:0] rd_addr,
    input  logic        rd_ack,
    input  logic [15:0] rd_data,
    output logic        busy,
    output logic        done,
    output logic [15:0] resp_pc,
    output logic [4:0]  resp_cycles,
    output logic        resp_nmi,
    output logic        resp_m0_exec,
    output logic        iff1,
    output logic        iff2,
    output logic [7:0]  i_reg,
    output logic [7:0]  r_reg,
    output logic [1:0]  im_mode,
    output logic [15:0] sp,
    output logic [15:0] af
);
    st_e               st_q, st_d;
    im_e               im_q, im_new;
    logic [ADDR_W-1:0] sp_q, af_q, ret_pc_q, new_pc_q, ptr_q;
    logic [BYTE_W-1:0] i_q, r_q;
    logic [CYC_W-1:0]  cyc_q;
    logic              iff1_q, iff2_q, nmi_prev_q, nmi_pend_q;
    logic              vec_q, m0_q, nmi_q;
    logic              nmi_now, grant_nmi, grant_int, grant_any;
    logic              set_en, clr_en, restore, im_we;
    plan_t             plan;

    assign nmi_now   = nmi_pend_q || (nmi_in && !nmi_prev_q);
    assign grant_any = grant_nmi || grant_int;

    irq_ctl_decode u_dec (
        .en(!busy), .op(ctl_op), .y(ctl_im_field),
        .set_en(set_en), .clr_en(clr_en), .restore(restore),
        .im_we(im_we), .im_new(im_new)
    );

    irq_arbiter u_arb (
        .boundary(instr_boundary), .busy(busy), .ctl_present(ctl_op != OP_NONE),
        .nmi_now(nmi_now), .int_req(int_req), .iff1(iff1_q),
        .grant_nmi(grant_nmi), .grant_int(grant_int)
    );

    irq_vector_calc #(.MASK_VEC_LSB(MASK_VEC_LSB)) u_vec (
        .is_nmi(nmi_now), .mode(im_q), .data(data_bus), .page(i_q),
        .pc_in(pc_in), .plan(plan)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (grant_any) st_d = plan.push ? ST_PUSH : ST_REPORT;
            ST_PUSH:   st_d = vec_q ? ST_VEC : ST_REPORT;
            ST_VEC:    if (rd_ack) st_d = ST_REPORT;
            ST_REPORT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy         = (st_q != ST_IDLE);
        wr_req       = (st_q == ST_PUSH);
        wr_addr      = sp_q - 16'd2;
        wr_data      = ret_pc_q;
        rd_req       = (st_q == ST_VEC);
        rd_addr      = ptr_q;
        done         = (st_q == ST_REPORT);
        resp_pc      = new_pc_q;
        resp_cycles  = cyc_q;
        resp_nmi     = nmi_q;
        resp_m0_exec = m0_q;
        iff1         = iff1_q;
        iff2         = iff2_q;
        i_reg        = i_q;
        r_reg        = r_q;
        im_mode      = im_q;
        sp           = sp_q;
        af           = af_q;
    end

    // architectural registers and response data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1_q <= 1'b0; iff2_q <= 1'b0;
            i_q <= '0; r_q <= '0; im_q <= IM0;
            sp_q <= '1; af_q <= '1;
            nmi_prev_q <= 1'b0; nmi_pend_q <= 1'b0;
            ret_pc_q <= '0; new_pc_q <= '0; ptr_q <= '0; cyc_q <= '0;
            vec_q <= 1'b0; m0_q <= 1'b0; nmi_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_in;
            nmi_pend_q <= nmi_now && !grant_nmi;

            if (grant_any) begin
                ret_pc_q <= pc_in;
                new_pc_q <= plan.pc;
                ptr_q    <= plan.pc;
                cyc_q    <= plan.cyc;
                vec_q    <= plan.vec_rd;
                m0_q     <= plan.m0_exec;
                nmi_q    <= grant_nmi;
            end else if (st_q == ST_VEC && rd_ack) begin
                new_pc_q <= rd_data;
            end

            if (grant_nmi) begin
                iff2_q <= iff1_q;
                iff1_q <= 1'b0;
            end else if (grant_int || clr_en) begin
                iff1_q <= 1'b0;
                iff2_q <= 1'b0;
            end else if (set_en) begin
                iff1_q <= 1'b1;
                iff2_q <= 1'b1;
            end else if (restore) begin
                iff1_q <= iff2_q;
            end

            if (im_we) im_q <= im_new;

            if (grant_any)            r_q <= {r_q[7], r_q[6:0] + 7'd1};
            else if (r_we && !busy)   r_q <= r_wdata;

            if (i_we && !busy) i_q <= i_wdata;

            if (st_q == ST_PUSH)      sp_q <= sp_q - 16'd2;
            else if (sp_we && !busy)  sp_q <= sp_wdata;

            if (af_we && !busy) af_q <= af_wdata;
        end
    end

    // R2: a masked request leaves the unit idle
    p_masked_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_boundary && !busy && ctl_op == OP_NONE && !iff1_q && !nmi_now) |=> !busy);
    // R3: maskable acceptance clears both flags
    p_int_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_int |=> (!iff1_q && !iff2_q));
    p_int_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_int |-> iff1_q);
    // R4: refresh bit 7 kept, low bits count up
    p_refresh_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |=> (r_q[7] == $past(r_q[7]) && r_q[6:0] == $past(r_q[6:0]) + 7'd1));
    // R5: the push lowers the stack pointer to the written address
    p_push_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (sp_q == $past(wr_addr)));
    // R8: NMI saves the live flag
    p_nmi_save_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_nmi |=> (iff2_q == $past(iff1_q) && !iff1_q));
    // R11: a boundary with a control code takes nothing
    p_ctl_defers_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_boundary && ctl_op != OP_NONE && !busy) |=> !busy);
    // R12: at most one source granted
    p_one_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_nmi, grant_int}));
    // R13: report is a single pulse and ends the response
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: tb/tb_irq_accept_unit.sv
`timescale 1ns/1ps
module tb_irq_accept_unit;
    logic clk = 1'b0, rst_n = 1'b0;
    logic instr_boundary = 0, int_req = 0, nmi_in = 0;
    logic [15:0] pc_in = 0;
    logic [7:0] data_bus = 0;
    logic [2:0] ctl_op = 0, ctl_im_field = 0;
    logic i_we = 0, r_we = 0, sp_we = 0, af_we = 0, rd_ack = 0;
    logic [7:0] i_wdata = 0, r_wdata = 0;
    logic [15:0] sp_wdata = 0, af_wdata = 0, rd_data = 0;
    logic wr_req, rd_req, busy, done, resp_nmi, resp_m0_exec, iff1, iff2;
    logic [15:0] wr_addr, wr_data, rd_addr, resp_pc, sp, af;
    logic [4:0] resp_cycles;
    logic [7:0] i_reg, r_reg;
    logic [1:0] im_mode;

    irq_accept_unit dut (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic m_iff1, m_iff2, m_pend;
    logic [7:0] m_i, m_r;
    logic [1:0] m_im;
    logic [15:0] m_sp;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] mode_of(input logic [2:0] y);
        if (y[1:0] <= 2'd1) return 2'd0;
        return y[0] ? 2'd2 : 2'd1;
    endfunction

    task automatic apply_ctl(input logic [2:0] op, input logic [2:0] y);
        case (op)
            3'd1: begin m_iff1 = 1; m_iff2 = 1; end
            3'd2: begin m_iff1 = 0; m_iff2 = 0; end
            3'd3: m_im = mode_of(y);
            3'd4, 3'd5: m_iff1 = m_iff2;
            default: ;
        endcase
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " iff1"}, iff1, m_iff1);
        chk({tag, " iff2"}, iff2, m_iff2);
        chk({tag, " im"}, im_mode, m_im);
        chk({tag, " refresh"}, r_reg, m_r);
        chk({tag, " sp"}, sp, m_sp);
    endtask

    // control code outside a boundary (R9, R10)
    task automatic ctl_only(input logic [2:0] op, input logic [2:0] y, input string tag);
        ctl_op = op; ctl_im_field = y;
        @(negedge clk);
        ctl_op = 0;
        apply_ctl(op, y);
        check_regs(tag);
    endtask

    task automatic write_regs(input bit wi, input logic [7:0] vi, input bit wr,
                              input logic [7:0] vr, input bit ws, input logic [15:0] vs);
        i_we = wi; i_wdata = vi; r_we = wr; r_wdata = vr; sp_we = ws; sp_wdata = vs;
        @(negedge clk);
        i_we = 0; r_we = 0; sp_we = 0;
        if (wi) m_i = vi;
        if (wr) m_r = vr;
        if (ws) m_sp = vs;
        chk("R1 page write", i_reg, m_i);
        check_regs("R4 regs after write");
    endtask

    task automatic bnd(input logic [15:0] pc, input bit irq, input bit nmi,
                       input logic [7:0] db, input logic [2:0] op, input logic [2:0] y);
        bit ok, g_nmi, g_int, nmi_now, push, vec, m0, saw_wr, saw_done;
        logic [15:0] exp_pc, ptr;
        logic [4:0] cyc;
        nmi_now = m_pend | nmi;
        ok = (op == 0);
        g_nmi = ok & nmi_now;
        g_int = ok & !nmi_now & irq & m_iff1;
        instr_boundary = 1; pc_in = pc; int_req = irq; nmi_in = nmi;
        data_bus = db; ctl_op = op; ctl_im_field = y;
        ptr = {m_i, db};
        push = 1; vec = 0; m0 = 0;
        if (g_nmi) begin exp_pc = 16'h0066; cyc = 11; end
        else if (m_im == 2'd1) begin exp_pc = 16'h0038; cyc = 13; end
        else if (m_im == 2'd2) begin exp_pc = 16'hxxxx; cyc = 19; vec = 1; end
        else if (db[7:6] == 2'b11 && db[2:0] == 3'b111) begin exp_pc = {10'd0, db[5:3], 3'd0}; cyc = 13; end
        else begin exp_pc = pc; cyc = 2; push = 0; m0 = 1; end
        @(negedge clk);
        instr_boundary = 0; int_req = 0; nmi_in = 0; ctl_op = 0;
        if (!ok) begin
            apply_ctl(op, y);
            if (nmi) m_pend = 1;
        end
        if (!(g_nmi || g_int)) begin
            chk("R2/R11 no acceptance busy", busy, 0);
            chk("R2/R11 no push", wr_req, 0);
            check_regs("R2/R11 state");
            return;
        end
        if (g_nmi) begin m_iff2 = m_iff1; m_iff1 = 0; m_pend = 0; end
        else begin m_iff1 = 0; m_iff2 = 0; end
        m_r = {m_r[7], m_r[6:0] + 7'd1};
        chk(g_nmi ? "R8 nmi flags" : "R3 flags cleared", {iff1, iff2}, {m_iff1, m_iff2});
        chk("R4 refresh step", r_reg, m_r);
        chk("R13 busy after accept", busy, 1);
        saw_wr = 0; saw_done = 0;
        for (int k = 0; k < 8 && !saw_done; k++) begin
            if (k > 0) @(negedge clk);
            rd_ack = 0;
            if (wr_req) begin
                saw_wr = 1;
                chk("R13 push in first cycle", k, 0);
                chk("R5 push address", wr_addr, m_sp - 16'd2);
                chk("R5 push data", wr_data, pc);
                m_sp = m_sp - 16'd2;
            end
            if (rd_req) begin
                chk("R6 pointer", rd_addr, ptr);
                rd_data = 16'($urandom);
                exp_pc = rd_data;
                rd_ack = 1;
            end
            if (done) begin
                saw_done = 1;
                chk("R5/R6/R7/R8 new pc", resp_pc, exp_pc);
                chk("R5/R6/R7/R8 cycles", resp_cycles, cyc);
                chk("R8 nmi flag", resp_nmi, g_nmi);
                chk("R7 exec flag", resp_m0_exec, m0);
            end
        end
        chk("R13 response reported", saw_done, 1);
        chk("R7 push presence", saw_wr, push);
        if (vec) chk("R6 vector read", exp_pc !== 16'hxxxx, 1);
        @(negedge clk);
        chk("R13 busy falls", busy, 0);
        check_regs("R13 state after response");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R13 watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        m_iff1 = 0; m_iff2 = 0; m_pend = 0; m_i = 0; m_r = 0; m_im = 0; m_sp = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 iff", {iff1, iff2}, 0);
        chk("R1 page", i_reg, 0);
        chk("R1 refresh", r_reg, 0);
        chk("R1 mode", im_mode, 0);
        chk("R1 sp", sp, 16'hFFFF);
        chk("R1 af", af, 16'hFFFF);
        chk("R1 busy", busy, 0);
        // R2 masked request
        bnd(16'h1234, 1, 0, 8'hFF, 0, 0);
        // R11 enable on the same boundary defers, next one accepts (mode 0 restart)
        bnd(16'h2000, 1, 0, 8'hEF, 3'd1, 0);
        bnd(16'h2001, 1, 0, 8'hEF, 0, 0);
        // R9 all mode fields
        for (int y = 0; y < 8; y++) ctl_only(3'd3, 3'(y), "R9 mode decode");
        // R5 mode 1 with refresh wrap 0x7F
        ctl_only(3'd3, 3'd2, "R9 to mode 1");
        write_regs(0, 0, 1, 8'h7F, 1, 16'h8000);
        ctl_only(3'd1, 0, "R10 enable");
        bnd(16'h4321, 1, 0, 8'h00, 0, 0);
        // R6 mode 2, bit 7 kept across wrap 0xFF
        ctl_only(3'd3, 3'd3, "R9 to mode 2");
        write_regs(1, 8'h12, 1, 8'hFF, 0, 0);
        ctl_only(3'd1, 0, "R10 enable");
        bnd(16'h5555, 1, 0, 8'h35, 0, 0);
        // R7 mode 0 plain byte
        ctl_only(3'd3, 3'd0, "R9 to mode 0");
        ctl_only(3'd1, 0, "R10 enable");
        bnd(16'h6000, 1, 0, 8'h3E, 0, 0);
        // R8 NMI with flag clear, then with flag set, then return
        bnd(16'h7000, 0, 1, 8'h00, 0, 0);
        ctl_only(3'd1, 0, "R10 enable");
        bnd(16'h7100, 0, 1, 8'h00, 0, 0);
        ctl_only(3'd5, 0, "R10 return-nmi restores");
        chk("R10 iff1 restored", iff1, 1);
        // R10 codes 6 and 7
        ctl_only(3'd6, 3'd7, "R10 code 6 no effect");
        ctl_only(3'd7, 3'd2, "R10 code 7 no effect");
        // R12 priority and latch: NMI edge on a disable boundary, taken at next one
        bnd(16'h7200, 1, 1, 8'h00, 3'd2, 0);
        ctl_only(3'd1, 0, "R10 enable");
        bnd(16'h7300, 1, 0, 8'hC7, 0, 0);
        chk("R12 latched nmi taken first", resp_nmi, 1);
        bnd(16'h7400, 1, 1, 8'hC7, 0, 0);
        // random mix
        for (int n = 0; n < 400; n++) begin
            int kind = $urandom % 6;
            logic [2:0] y = 3'($urandom);
            logic [7:0] db = ($urandom % 2) ? {2'b11, y, 3'b111} : 8'($urandom);
            logic [2:0] op = ($urandom % 3 == 0) ? 3'($urandom) : 3'd0;
            if (kind < 3) bnd(16'($urandom), 1'($urandom), ($urandom % 5 == 0), db, op, y);
            else if (kind < 5) ctl_only(3'($urandom), y, "R9/R10 random control");
            else write_regs(1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom),
                            1'($urandom), 16'($urandom));
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule